// File: doc/BRIEF.md
# Tri-State Phase-Frequency Detector

This block compares a divided reference with a divided oscillator feedback for each of several phase-locked loops. Both inputs arrive as single-cycle strobes in the system clock domain. Each loop has a pair of flip-flops: one is set by a reference strobe and the other by a feedback strobe. When both are set, they clear together. The error output of each loop takes one of three states, carried on two wires. The enable wire drives the pad and the level wire gives the polarity. The output drives high when the feedback lags the reference or runs slower than it. It drives low when the feedback leads or runs faster. It is released when the two inputs match in phase and frequency.

One loop, chosen by a parameter, also feeds an out-of-lock flag. The flag is high while that loop has held an error pulse for longer than a set number of system clocks. Each loop has its own power-down input. While it is high, that loop's detector is held idle and all of its strobes are ignored.

Top module: `pfd_dual`

## Requirements
- R1: While reset is high, and in the first cycle after it, every `err_oe` bit, every `err_level` bit and `out_of_lock` are 0.
- R2: A reference strobe with no feedback strobe, arriving at an idle loop, makes that loop drive high (`err_oe`=1, `err_level`=1) from the next cycle.
- R3: A feedback strobe with no reference strobe, arriving at an idle loop, makes that loop drive low (`err_oe`=1, `err_level`=0) from the next cycle.
- R4: A pulse ends when a strobe arrives on the opposite input. The output is released (`err_oe`=0) in the cycle after that strobe, so the pulse length in cycles equals the distance between the two strobes.
- R5: A reference strobe and a feedback strobe in the same cycle at an idle loop produce no pulse.
- R6: Further strobes on the side that is already pending do not change the output. The pulse goes on until the opposite strobe arrives.
- R7: While a loop's `pwr_down` bit is high, that loop's `err_oe` is 0 from the next cycle and its strobes are ignored. After `pwr_down` falls, the loop starts idle.
- R8: `out_of_lock` is 1 exactly when loop `LOCK_SRC` is driving and has been driving for more than `LOCK_LIMIT` consecutive cycles, counting the current cycle. It is 0 as soon as that loop is released.
- R9: Error pulses on any loop other than `LOCK_SRC` never raise `out_of_lock`.
- R10: The loops are independent: strobes and power-down on one loop never change another loop's output.
- R11: When `err_oe` is 0, the matching `err_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_strobe | input | NUM_LOOPS | Divided reference edge strobe, one bit per loop |
| fb_strobe | input | NUM_LOOPS | Divided feedback edge strobe, one bit per loop |
| pwr_down | input | NUM_LOOPS | Holds a loop's detector idle |
| err_oe | output | NUM_LOOPS | Error output enable; 0 means released (high impedance) |
| err_level | output | NUM_LOOPS | Error polarity when enabled: 1 high, 0 low |
| out_of_lock | output | 1 | High while loop LOCK_SRC holds an error longer than LOCK_LIMIT cycles |

## Verification
The bench targets several corner cases. Coincident strobes on an idle loop are one of them: a detector that sets both flip-flops before clearing them would emit a one-cycle glitch. Repeated strobes on the pending side are another: a toggling design would end the pulse early. The bench also applies power-down while a pulse is in flight. A design that only gates the output would leave a stale pending flip-flop, and the loop would drive again when power-down is released. The lock flag is checked at the exact cycle its threshold is crossed, so an off-by-one timer shows up. Pulses on the non-selected loop are checked as well, to catch a flag that mixes in every loop.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef struct packed {
        logic ref_ahead;
        logic fb_ahead;
    } pfd_state_t;

    typedef enum logic [1:0] {
        DRV_FLOAT = 2'd0,
        DRV_LOW   = 2'd1,
        DRV_HIGH  = 2'd2
    } drive_t;

    localparam pfd_state_t PFD_IDLE = '{ref_ahead: 1'b0, fb_ahead: 1'b0};

    function automatic pfd_state_t pfd_advance(pfd_state_t cur, logic ref_hit, logic fb_hit);
        pfd_state_t nxt;
        nxt.ref_ahead = cur.ref_ahead | ref_hit;
        nxt.fb_ahead  = cur.fb_ahead | fb_hit;
        if (nxt.ref_ahead && nxt.fb_ahead) begin
            nxt = PFD_IDLE;
        end
        return nxt;
    endfunction

    function automatic drive_t pfd_decode(pfd_state_t s);
        if (s.ref_ahead && !s.fb_ahead) return DRV_HIGH;
        if (s.fb_ahead && !s.ref_ahead) return DRV_LOW;
        return DRV_FLOAT;
    endfunction

endpackage

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idle_force,
    input  logic       ref_hit,
    input  logic       fb_hit,
    output pfd_state_t state
);

    pfd_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst || idle_force) begin
            state_q <= PFD_IDLE;
        end else begin
            state_q <= pfd_advance(state_q, ref_hit, fb_hit);
        end
    end

    assign state = state_q;

endmodule

// File: rtl/pfd_drive.sv
module pfd_drive
    import pfd_pkg::*;
(
    input  pfd_state_t state,
    output logic       oe,
    output logic       level
);

    drive_t code;

    always_comb begin
        code  = pfd_decode(state);
        oe    = (code != DRV_FLOAT);
        level = (code == DRV_HIGH);
    end

endmodule

// File: rtl/pfd_lock_timer.sv
module pfd_lock_timer #(
    parameter int LOCK_LIMIT = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic idle_force,
    input  logic active,
    output logic unlocked
);

    localparam int CNT_W = $clog2(LOCK_LIMIT + 1) + 1;
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LOCK_LIMIT);

    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || idle_force) begin
            run_q <= '0;
        end else if (active) begin
            if (run_q < LIMIT_V) begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    assign unlocked = active && (run_q >= LIMIT_V);

endmodule

// File: rtl/pfd_dual.sv
module pfd_dual
    import pfd_pkg::*;
#(
    parameter int NUM_LOOPS  = 2,
    parameter int LOCK_SRC   = 0,
    parameter int LOCK_LIMIT = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LOOPS-1:0] ref_strobe,
    input  logic [NUM_LOOPS-1:0] fb_strobe,
    input  logic [NUM_LOOPS-1:0] pwr_down,
    output logic [NUM_LOOPS-1:0] err_oe,
    output logic [NUM_LOOPS-1:0] err_level,
    output logic                 out_of_lock
);

    pfd_state_t loop_state [NUM_LOOPS];
    logic       lock_active;

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
        pfd_core u_core (
            .clk        (clk),
            .rst        (rst),
            .idle_force (pwr_down[g]),
            .ref_hit    (ref_strobe[g]),
            .fb_hit     (fb_strobe[g]),
            .state      (loop_state[g])
        );

        pfd_drive u_drive (
            .state (loop_state[g]),
            .oe    (err_oe[g]),
            .level (err_level[g])
        );
    end

    assign lock_active = loop_state[LOCK_SRC].ref_ahead ^ loop_state[LOCK_SRC].fb_ahead;

    pfd_lock_timer #(.LOCK_LIMIT(LOCK_LIMIT)) u_lock (
        .clk        (clk),
        .rst        (rst),
        .idle_force (pwr_down[LOCK_SRC]),
        .active     (lock_active),
        .unlocked   (out_of_lock)
    );

endmodule

// File: rtl/pfd_dual_checker.sv
module pfd_dual_checker #(
    parameter int NUM_LOOPS  = 2,
    parameter int LOCK_SRC   = 0,
    parameter int LOCK_LIMIT = 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LOOPS-1:0] ref_strobe,
    input logic [NUM_LOOPS-1:0] fb_strobe,
    input logic [NUM_LOOPS-1:0] pwr_down,
    input logic [NUM_LOOPS-1:0] err_oe,
    input logic [NUM_LOOPS-1:0] err_level,
    input logic                 out_of_lock
);

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_chk
        assert_ref_drives_high_R2: assert property (@(posedge clk) disable iff (rst)
            (!err_oe[g] && ref_strobe[g] && !fb_strobe[g] && !pwr_down[g])
            |=> (err_oe[g] && err_level[g]));

        assert_fb_drives_low_R3: assert property (@(posedge clk) disable iff (rst)
            (!err_oe[g] && fb_strobe[g] && !ref_strobe[g] && !pwr_down[g])
            |=> (err_oe[g] && !err_level[g]));

        assert_high_ends_on_fb_R4: assert property (@(posedge clk) disable iff (rst)
            (err_oe[g] && err_level[g] && fb_strobe[g]) |=> !err_oe[g]);

        assert_low_ends_on_ref_R4: assert property (@(posedge clk) disable iff (rst)
            (err_oe[g] && !err_level[g] && ref_strobe[g]) |=> !err_oe[g]);

        assert_coincident_silent_R5: assert property (@(posedge clk) disable iff (rst)
            (!err_oe[g] && ref_strobe[g] && fb_strobe[g]) |=> !err_oe[g]);

        assert_powerdown_idle_R7: assert property (@(posedge clk) disable iff (rst)
            pwr_down[g] |=> !err_oe[g]);

        assert_released_level_R11: assert property (@(posedge clk) disable iff (rst)
            !err_oe[g] |-> !err_level[g]);
    end

    assert_lock_needs_error_R8: assert property (@(posedge clk) disable iff (rst)
        out_of_lock |-> err_oe[LOCK_SRC]);

    assert_lock_needs_history_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(err_oe[LOCK_SRC]) |-> !out_of_lock);

endmodule

bind pfd_dual pfd_dual_checker #(
    .NUM_LOOPS  (NUM_LOOPS),
    .LOCK_SRC   (LOCK_SRC),
    .LOCK_LIMIT (LOCK_LIMIT)
) u_checker (.*);

// File: tb/pfd_dual_test.sv
module pfd_dual_test;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 2;
    localparam int SRC        = 0;
    localparam int LIM        = 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] ref_strobe = '0;
    logic [NL-1:0] fb_strobe  = '0;
    logic [NL-1:0] pwr_down   = '0;
    logic [NL-1:0] err_oe;
    logic [NL-1:0] err_level;
    logic          out_of_lock;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model of each loop: pending-high, pending-low, run length
    bit m_hi [NL];
    bit m_lo [NL];
    int m_run;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfd_dual #(.NUM_LOOPS(NL), .LOCK_SRC(SRC), .LOCK_LIMIT(LIM)) uut (
        .clk         (clk),
        .rst         (rst),
        .ref_strobe  (ref_strobe),
        .fb_strobe   (fb_strobe),
        .pwr_down    (pwr_down),
        .err_oe      (err_oe),
        .err_level   (err_level),
        .out_of_lock (out_of_lock)
    );

    function automatic bit exp_lock();
        return (m_hi[SRC] ^ m_lo[SRC]) && (m_run >= LIM);
    endfunction

    function automatic void model_step(logic [NL-1:0] r, logic [NL-1:0] f, logic [NL-1:0] p);
        bit act;
        act = m_hi[SRC] ^ m_lo[SRC];
        if (p[SRC]) m_run = 0;
        else if (act) m_run = (m_run < LIM) ? m_run + 1 : m_run;
        else m_run = 0;
        for (int i = 0; i < NL; i++) begin
            bit h, l;
            h = m_hi[i] | r[i];
            l = m_lo[i] | f[i];
            if (h && l) begin h = 0; l = 0; end
            if (p[i]) begin h = 0; l = 0; end
            m_hi[i] = h;
            m_lo[i] = l;
        end
    endfunction

    task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_outputs(input string tag, input string ltag);
        for (int i = 0; i < NL; i++) begin
            check_bit(tag, $sformatf("err_oe[%0d]", i), err_oe[i], m_hi[i] ^ m_lo[i]);
            check_bit(tag, $sformatf("err_level[%0d]", i), err_level[i], m_hi[i] & ~m_lo[i]);
        end
        check_bit(ltag, "out_of_lock", out_of_lock, exp_lock());
    endtask

    // drive at negedge, model updates at posedge, check at next negedge
    task automatic cyc(input logic [NL-1:0] r, input logic [NL-1:0] f, input logic [NL-1:0] p,
                       input string tag, input string ltag);
        ref_strobe = r;
        fb_strobe  = f;
        pwr_down   = p;
        @(posedge clk);
        model_step(r, f, p);
        @(negedge clk);
        check_outputs(tag, ltag);
    endtask

    task automatic idle(input int n, input string tag, input string ltag);
        for (int k = 0; k < n; k++) cyc('0, '0, '0, tag, ltag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NL; i++) begin m_hi[i] = 0; m_lo[i] = 0; end
        m_run = 0;
        rst = 1'b1;
        ref_strobe = '1;
        fb_strobe  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_outputs("R1", "R1");
        ref_strobe = '0;
        rst = 1'b0;
        @(negedge clk);
        check_outputs("R1", "R1");

        // R2 then R4: loop 0 high pulse 5 cycles, lock crosses threshold (R8)
        cyc(2'b01, 2'b00, 2'b00, "R2", "R8");
        idle(4, "R2", "R8");
        cyc(2'b00, 2'b01, 2'b00, "R4", "R8");
        idle(2, "R4", "R8");

        // R3 then R4 on loop 1, long pulse must not raise lock (R9)
        cyc(2'b00, 2'b10, 2'b00, "R3", "R9");
        idle(6, "R3", "R9");
        cyc(2'b10, 2'b00, 2'b00, "R4", "R9");

        // R5 coincident strobes on both loops
        cyc(2'b11, 2'b11, 2'b00, "R5", "R5");
        idle(2, "R5", "R5");

        // R6 repeated pending-side strobes on loop 0
        cyc(2'b00, 2'b01, 2'b00, "R6", "R8");
        cyc(2'b00, 2'b01, 2'b00, "R6", "R8");
        cyc(2'b00, 2'b01, 2'b00, "R6", "R8");
        cyc(2'b01, 2'b01, 2'b00, "R6", "R8");
        idle(1, "R6", "R8");

        // one-cycle pulse never flags lock (R8 boundary)
        cyc(2'b01, 2'b00, 2'b00, "R2", "R8");
        cyc(2'b00, 2'b01, 2'b00, "R4", "R8");

        // R7 power-down mid-pulse, strobes ignored, idle on release; R10 other loop unaffected
        cyc(2'b11, 2'b00, 2'b00, "R2", "R8");
        cyc(2'b00, 2'b00, 2'b00, "R2", "R8");
        cyc(2'b01, 2'b01, 2'b01, "R7", "R7");
        cyc(2'b01, 2'b00, 2'b01, "R7", "R7");
        idle(2, "R10", "R7");
        cyc(2'b00, 2'b10, 2'b00, "R4", "R7");

        // R10/R11 random mix
        for (int n = 0; n < 4000; n++) begin
            logic [NL-1:0] r, f, p;
            for (int i = 0; i < NL; i++) begin
                r[i] = ($urandom % 8) == 0;
                f[i] = ($urandom % 8) == 0;
                p[i] = ($urandom % 40) == 0;
            end
            cyc(r, f, p, "R10", "R8");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule